// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block is the control slice of an 8-bit processor that handles the unconditional three-byte subroutine call and its matching return. It holds the 16-bit program counter and the 16-bit stack pointer. It drives a byte-wide memory port. Whoever decodes instructions gives it a one-cycle start strobe together with the opcode byte already fetched from the address in the program counter.

For a call, the block reads the two operand bytes that follow the opcode. It then saves the address of the next instruction, which is the program counter plus three, as two bytes on a stack that grows downward. Finally it moves the stack pointer down by two and loads the program counter with the operand address.

For a return, it reads the two saved bytes back, loads them into the program counter and moves the stack pointer up by two. A one-cycle done strobe marks the first cycle in which the program counter shows its new value.

Top module: `call_stack_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, `pc_o` equals `PC_RESET` (default 16'h0100), `sp_o` equals `SP_RESET` (default 16'h0000), and `busy`, `done`, `mem_rd` and `mem_wr` are all 0.
- R2: A start with opcode `OP_CALL` (default 8'hCD) reads the low target byte at PC+1 in the first busy cycle and the high target byte at PC+2 in the second busy cycle. The program counter then becomes {high, low}.
- R3: A call writes the return address PC+3 in two consecutive cycles, the third and fourth busy cycles. The high byte goes to SP-1 first, then the low byte goes to SP-2.
- R4: A call lowers the stack pointer by exactly 2, modulo 2^16 (16'h0000 becomes 16'hFFFE).
- R5: A start with opcode `OP_RET` (default 8'hC9) reads the low byte at SP in the first busy cycle and the high byte at SP+1 in the second busy cycle. PC then becomes {high, low} and SP rises by 2, modulo 2^16.
- R6: `done` is a single-cycle pulse. For a call it appears four clock edges after the accepting edge, for a return three. In that same cycle `pc_o` and `sp_o` show their new values and `busy` is 0.
- R7: A start whose opcode is neither `OP_CALL` nor `OP_RET`, and any start while `busy` is 1, has no effect. It raises no busy, makes no memory access, and leaves PC and SP unchanged.
- R8: Two nested calls followed by two returns end with PC at the address after the outer call and SP back at its value before the outer call.
- R9: `mem_rd` and `mem_wr` are never 1 together, and PC and SP hold their values on every edge other than the one that completes an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle instruction start strobe |
| opcode | input | 8 | Opcode byte qualified by `start` |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| busy | output | 1 | A call or return is in progress |
| done | output | 1 | Program counter has just taken its new value |

## Verification
The embedded properties check, on every cycle, the local rules of the bus and the registers. Reads and writes never overlap. Stack writes come in pairs at descending addresses. Back-to-back reads step upward by one. The done pulse lasts one cycle and follows a busy cycle. PC and SP change only on a completing edge. Only the bench scenarios can show the end-to-end values. These are the jump target assembled from operand bytes, the return address placed on the stack, the wraparound of SP in both directions, a start that is ignored during a call or for a foreign opcode, and a nested call pair unwinding to the original stack pointer.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TGT_LO,
        ST_TGT_HI,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_POP_LO,
        ST_POP_HI,
        ST_RELOAD
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic [7:0] lo;
        logic [7:0] hi;
        logic       done;
    } seq_reg_t;

    typedef struct packed {
        logic [15:0] pc;
        logic [15:0] sp;
    } ptr_reg_t;

endpackage

// File: rtl/csc_ptr.sv
module csc_ptr #(
    parameter int          AW       = 16,
    parameter logic [15:0] PC_RESET = 16'h0100,
    parameter logic [15:0] SP_RESET = 16'h0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_call,
    input  logic          ld_ret,
    input  logic [AW-1:0] ld_pc,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp
);
    import csc_pkg::*;

    localparam logic [AW-1:0] STEP = AW'(2);

    ptr_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ld_call) begin
            r_d.pc = ld_pc;
            r_d.sp = r_q.sp - STEP;
        end else if (ld_ret) begin
            r_d.pc = ld_pc;
            r_d.sp = r_q.sp + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.pc <= PC_RESET;
            r_q.sp <= SP_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc = r_q.pc;
    assign sp = r_q.sp;

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_call || ld_ret) |=> ($stable(pc) && $stable(sp)));

    // R4
    ptr_call_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_call |=> (sp == $past(sp) - STEP));

endmodule

// File: rtl/csc_seq.sv
module csc_seq #(
    parameter int         AW      = 16,
    parameter logic [7:0] OP_CALL = 8'hCD,
    parameter logic [7:0] OP_RET  = 8'hC9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [7:0]    mem_rdata,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] sp,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          ld_call,
    output logic          ld_ret,
    output logic [AW-1:0] ld_pc,
    output logic          busy,
    output logic          done
);
    import csc_pkg::*;

    localparam logic [AW-1:0] ONE   = AW'(1);
    localparam logic [AW-1:0] TWO   = AW'(2);
    localparam logic [AW-1:0] THREE = AW'(3);

    seq_reg_t s_d, s_q;
    logic [AW-1:0] link_addr;

    assign link_addr = pc + THREE;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ld_call   = 1'b0;
        ld_ret    = 1'b0;
        ld_pc     = {s_q.hi, s_q.lo};
        case (s_q.st)
            ST_IDLE: begin
                if (start && opcode == OP_CALL) begin
                    s_d.st = ST_TGT_LO;
                end else if (start && opcode == OP_RET) begin
                    s_d.st = ST_POP_LO;
                end
            end
            ST_TGT_LO: begin
                mem_rd   = 1'b1;
                mem_addr = pc + ONE;
                s_d.st   = ST_TGT_HI;
            end
            ST_TGT_HI: begin
                mem_rd   = 1'b1;
                mem_addr = pc + TWO;
                s_d.lo   = mem_rdata;
                s_d.st   = ST_PUSH_HI;
            end
            ST_PUSH_HI: begin
                s_d.hi    = mem_rdata;
                mem_wr    = 1'b1;
                mem_addr  = sp - ONE;
                mem_wdata = link_addr[15:8];
                s_d.st    = ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = sp - TWO;
                mem_wdata = link_addr[7:0];
                ld_call   = 1'b1;
                s_d.done  = 1'b1;
                s_d.st    = ST_IDLE;
            end
            ST_POP_LO: begin
                mem_rd   = 1'b1;
                mem_addr = sp;
                s_d.st   = ST_POP_HI;
            end
            ST_POP_HI: begin
                mem_rd   = 1'b1;
                mem_addr = sp + ONE;
                s_d.lo   = mem_rdata;
                s_d.st   = ST_RELOAD;
            end
            ST_RELOAD: begin
                ld_ret   = 1'b1;
                ld_pc    = {mem_rdata, s_q.lo};
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.lo   <= '0;
            s_q.hi   <= '0;
            s_q.done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st != ST_IDLE);
    assign done = s_q.done;

    // R9
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3
    push_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !$past(mem_wr)) |=> mem_wr);

    // R3
    push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) - ONE));

    // R2
    read_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + ONE));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R7
    foreign_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && opcode != OP_CALL && opcode != OP_RET) |=> !busy);

endmodule

// File: rtl/call_stack_ctl.sv
module call_stack_ctl #(
    parameter int          AW       = 16,
    parameter logic [7:0]  OP_CALL  = 8'hCD,
    parameter logic [7:0]  OP_RET   = 8'hC9,
    parameter logic [15:0] PC_RESET = 16'h0100,
    parameter logic [15:0] SP_RESET = 16'h0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [7:0]    mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] sp_o,
    output logic          busy,
    output logic          done
);
    logic          ld_call;
    logic          ld_ret;
    logic [AW-1:0] ld_pc;

    csc_seq #(
        .AW     (AW),
        .OP_CALL(OP_CALL),
        .OP_RET (OP_RET)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .opcode   (opcode),
        .mem_rdata(mem_rdata),
        .pc       (pc_o),
        .sp       (sp_o),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .ld_call  (ld_call),
        .ld_ret   (ld_ret),
        .ld_pc    (ld_pc),
        .busy     (busy),
        .done     (done)
    );

    csc_ptr #(
        .AW      (AW),
        .PC_RESET(PC_RESET),
        .SP_RESET(SP_RESET)
    ) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_call(ld_call),
        .ld_ret (ld_ret),
        .ld_pc  (ld_pc),
        .pc     (pc_o),
        .sp     (sp_o)
    );

endmodule

// File: tb/call_stack_ctl_test.sv
module call_stack_ctl_test;

    localparam logic [7:0] CALL_OP = 8'hCD;
    localparam logic [7:0] RET_OP  = 8'hC9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_rd, mem_wr, busy, done;
    logic [15:0] mem_addr, pc_o, sp_o;
    logic [7:0]  mem_wdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] mem [bit [15:0]];

    // reference model state
    logic [15:0] m_pc = 16'h0100, m_sp = 16'h0000, m_tgt = '0, m_link = '0, m_spn = '0;
    int          m_left = 0;
    bit          m_call = 0, m_busy = 0, m_done = 0;

    always #10 clk = ~clk;

    call_stack_ctl uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pc_o(pc_o), .sp_o(sp_o), .busy(busy), .done(done)
    );

    function automatic logic [7:0] peek(input logic [15:0] a);
        if (mem.exists(a)) return mem[a];
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= peek(mem_addr);
        if (mem_wr) mem[mem_addr] = mem_wdata;
    end

    // behavioural reference, advanced on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 16'h0100; m_sp = 16'h0000; m_left = 0; m_busy = 0; m_done = 0;
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
                m_pc = m_tgt; m_sp = m_spn; m_done = 1; m_busy = 0;
            end else begin
                m_done = 0;
            end
        end else begin
            m_done = 0;
            if (start && opcode == CALL_OP) begin
                m_call = 1; m_busy = 1; m_left = 4;
                m_tgt  = {peek(m_pc + 16'd2), peek(m_pc + 16'd1)};
                m_link = m_pc + 16'd3;
                m_spn  = m_sp - 16'd2;
            end else if (start && opcode == RET_OP) begin
                m_call = 0; m_busy = 1; m_left = 3;
                m_tgt  = {peek(m_sp + 16'd1), peek(m_sp)};
                m_spn  = m_sp + 16'd2;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit          x_rd, x_wr;
            logic [15:0] x_addr;
            logic [7:0]  x_wd;
            x_rd = 0; x_wr = 0; x_addr = '0; x_wd = '0;
            if (m_call && m_left == 4) begin x_rd = 1; x_addr = m_pc + 16'd1; end
            if (m_call && m_left == 3) begin x_rd = 1; x_addr = m_pc + 16'd2; end
            if (m_call && m_left == 2) begin x_wr = 1; x_addr = m_sp - 16'd1; x_wd = m_link[15:8]; end
            if (m_call && m_left == 1) begin x_wr = 1; x_addr = m_sp - 16'd2; x_wd = m_link[7:0]; end
            if (!m_call && m_left == 3) begin x_rd = 1; x_addr = m_sp; end
            if (!m_call && m_left == 2) begin x_rd = 1; x_addr = m_sp + 16'd1; end
            chk(pc_o == m_pc, "R2/R5 pc", 32'(pc_o), 32'(m_pc));
            chk(sp_o == m_sp, "R4/R5 sp", 32'(sp_o), 32'(m_sp));
            chk(busy == m_busy, "R7 busy", 32'(busy), 32'(m_busy));
            chk(done == m_done, "R6 done", 32'(done), 32'(m_done));
            chk(mem_rd == x_rd && mem_wr == x_wr, "R9 strobes",
                32'({mem_rd, mem_wr}), 32'({x_rd, x_wr}));
            if (x_rd || x_wr)
                chk(mem_addr == x_addr, "R2/R3/R5 addr", 32'(mem_addr), 32'(x_addr));
            if (x_wr)
                chk(mem_wdata == x_wd, "R3 wdata", 32'(mem_wdata), 32'(x_wd));
        end
    end

    task automatic issue(input logic [7:0] op);
        @(negedge clk);
        start = 1'b1; opcode = op;
        @(negedge clk);
        start = 1'b0; opcode = 8'h00;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20) begin @(negedge clk); n++; end
        chk(done == 1'b1, "R6 done seen", 32'(done), 32'd1);
    endtask

    initial begin
        mem[16'h0101] = 8'h34; mem[16'h0102] = 8'h12;
        mem[16'h1235] = 8'h78; mem[16'h1236] = 8'h56;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(pc_o == 16'h0100 && sp_o == 16'h0000, "R1 ptrs", 32'({pc_o, sp_o}), 32'h01000000);
        chk(!busy && !done && !mem_rd && !mem_wr, "R1 idle", 32'({busy, done, mem_rd, mem_wr}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_o == 16'h0100 && !busy, "R1 after reset", 32'(pc_o), 32'h0100);

        // R7: foreign opcode
        issue(8'h00);
        repeat (3) @(negedge clk);
        chk(!busy && pc_o == 16'h0100 && sp_o == 16'h0000, "R7 foreign op", 32'({pc_o, sp_o}), 32'h01000000);

        // outer call, stack wraps below zero (R2, R3, R4)
        issue(CALL_OP);
        wait_done();
        chk(pc_o == 16'h1234, "R2 target", 32'(pc_o), 32'h1234);
        chk(sp_o == 16'hFFFE, "R4 wrap", 32'(sp_o), 32'hFFFE);
        chk(peek(16'hFFFF) == 8'h01 && peek(16'hFFFE) == 8'h03, "R3 pushed link",
            32'({peek(16'hFFFF), peek(16'hFFFE)}), 32'h0103);
        @(negedge clk);
        chk(!done, "R6 single pulse", 32'(done), 32'd0);

        // nested call with a return strobe inside it (R7)
        @(negedge clk);
        start = 1'b1; opcode = CALL_OP;
        @(negedge clk);
        start = 1'b1; opcode = RET_OP;
        @(negedge clk);
        start = 1'b0; opcode = 8'h00;
        wait_done();
        chk(pc_o == 16'h5678 && sp_o == 16'hFFFC, "R7 busy start ignored", 32'({pc_o, sp_o}), 32'h5678FFFC);
        chk(peek(16'hFFFD) == 8'h12 && peek(16'hFFFC) == 8'h37, "R3 nested link",
            32'({peek(16'hFFFD), peek(16'hFFFC)}), 32'h1237);
        @(negedge clk);
        chk(!busy, "R7 no restart", 32'(busy), 32'd0);

        // unwind (R5, R8)
        issue(RET_OP);
        wait_done();
        chk(pc_o == 16'h1237 && sp_o == 16'hFFFE, "R5 inner return", 32'({pc_o, sp_o}), 32'h1237FFFE);
        issue(RET_OP);
        wait_done();
        chk(pc_o == 16'h0103 && sp_o == 16'h0000, "R8 unwound", 32'({pc_o, sp_o}), 32'h01030000);
        repeat (4) @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule